// File: doc/BRIEF.md
# Coarse/Fine Period Comparator for Motor Speed Locking

This block compares the period of a motor feedback signal against a programmed target period. It drives an UP or DOWN correction pulse toward a charge pump. The target is held as two register values: a coarse count of long ticks and a fine count of short ticks. Both tick kinds are derived from the system clock. Each rising edge that the prescaler lets through starts a new target period. The position of the next such edge inside or after that period decides which pulse is produced and how long it lasts. The pulse width equals the period error in system clock cycles, so the correction is proportional rather than a plain lead/lag flag. The span of the fine window caps that width.

A prescaler selects whether one measurement covers one feedback period (one electrical period) or a group of 4 or 6 feedback periods (one revolution of an 8-pole or 12-pole motor). Two test inputs force the source or sink output on regardless of the comparison.

Top module: `speed_period_cmp`

## Requirements
- R1: While reset is high, and after it is released until forced or compared otherwise, `up_o` and `dn_o` are low. The first qualifying edge after reset only starts a target period and produces no pulse.
- R2: The target period is T = coarse_i × 320 + fine_i × 20 clock cycles, counted from the qualifying edge. The next qualifying edge arriving exactly T cycles later produces no pulse.
- R3: When the next qualifying edge arrives d < T cycles after the previous one, `dn_o` rises the cycle after that edge and stays high for min(T − d, fine_i × 20) cycles.
- R4: When the next qualifying edge arrives d > T cycles after the previous one, `up_o` is high for min(d − T, fine_i × 20) cycles, starting T cycles after the previous edge. It drops at that edge if the edge comes first.
- R5: If no qualifying edge arrives, `up_o` stays high for fine_i × 20 cycles after the target expires and then stays low. The next edge starts a fresh target period without any pulse.
- R6: With fine_i = 0 the correction limit is zero and neither output ever pulses from the comparison.
- R7: ps_sel_i selects how many rising feedback edges make one qualifying edge: 0 → 1, 1 → 4, 2 → 6, 3 → 1. The counter starts at reset, so the Nth rising edge is the first qualifying one.
- R8: force_up_i drives `up_o` high and `dn_o` low in the same cycle. force_dn_i without force_up_i drives `dn_o` high and `up_o` low. force_up_i wins when both are set.
- R9: `up_o` and `dn_o` are never high together.
- R10: With coarse_i = 0 the target period consists of the fine phase alone, so T = fine_i × 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fb_i | input | 1 | Motor feedback signal; rising edges are counted |
| coarse_i | input | CRS_W | Target coarse count, in 320-cycle ticks |
| fine_i | input | FIN_W | Target fine count, in 20-cycle ticks; also the pulse-width cap |
| ps_sel_i | input | 2 | Prescaler select (0:/1, 1:/4, 2:/6, 3:/1) |
| force_up_i | input | 1 | Test force of the source output |
| force_dn_i | input | 1 | Test force of the sink output |
| up_o | output | 1 | Source (speed-up) correction pulse |
| dn_o | output | 1 | Sink (slow-down) correction pulse |

## Verification
A feedback rise is driven on a falling clock edge and is taken at the next rising edge. A DOWN pulse therefore shows at the following falling edge and lasts exactly its width in cycles. An UP pulse appears T rising edges after the edge that started the period and ends at the rising edge that takes the next qualifying edge. The driver queues the expected kind and width of each gap before driving it. The monitor counts high samples on falling edges and compares a whole pulse only once it has ended, so no check depends on a single-cycle alignment. The forced outputs are combinational and are checked a fraction of a cycle after the force input changes.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COARSE = 2'd1,
        PH_FINE   = 2'd2,
        PH_LATE   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        PS_DIV1 = 2'd0,
        PS_DIV4 = 2'd1,
        PS_DIV6 = 2'd2,
        PS_ALT1 = 2'd3
    } ps_sel_e;

    localparam int unsigned PS_CW = 3;

endpackage

// File: rtl/spc_tick_div.sv
module spc_tick_div #(
    parameter  int unsigned DIV = 20,
    localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clear_i,
    output logic          tick_o,
    output logic [CW-1:0] phase_o
);

    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o  = (st_q.cnt == LAST);
    assign phase_o = st_q.cnt;

endmodule

// File: rtl/spc_prescale.sv
module spc_prescale
    import spc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       fb_i,
    input  logic [1:0] sel_i,
    output logic       meas_o
);

    typedef struct packed {
        logic             fb;
        logic [PS_CW-1:0] cnt;
    } ps_state_t;

    ps_state_t       st_d, st_q;
    logic            rise;
    logic [PS_CW-1:0] last_idx;

    always_comb begin
        case (ps_sel_e'(sel_i))
            PS_DIV4: last_idx = PS_CW'(3);
            PS_DIV6: last_idx = PS_CW'(5);
            default: last_idx = '0;
        endcase
    end

    assign rise   = fb_i && !st_q.fb;
    assign meas_o = rise && (st_q.cnt >= last_idx);

    always_comb begin
        st_d    = st_q;
        st_d.fb = fb_i;
        if (meas_o) begin
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.cnt = st_q.cnt + PS_CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_count_cap_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= PS_CW'(5));

    assert_single_div_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise && (sel_i == 2'd0 || sel_i == 2'd3)) |-> meas_o);

endmodule

// File: rtl/spc_ref_cmp.sv
module spc_ref_cmp
    import spc_pkg::*;
#(
    parameter  int unsigned COARSE_DIV = 320,
    parameter  int unsigned FINE_DIV   = 20,
    parameter  int unsigned CRS_W      = 6,
    parameter  int unsigned FIN_W      = 5,
    localparam int unsigned LIM_MAX    = ((1 << FIN_W) - 1) * FINE_DIV,
    localparam int unsigned DW         = $clog2(LIM_MAX + 1),
    localparam int unsigned CSW        = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1,
    localparam int unsigned FSW        = (FINE_DIV > 1) ? $clog2(FINE_DIV) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             meas_i,
    input  logic [CRS_W-1:0] coarse_i,
    input  logic [FIN_W-1:0] fine_i,
    output logic             late_o,
    output logic             early_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CRS_W-1:0] ccnt;
        logic [FIN_W-1:0] fcnt;
        logic [DW-1:0]    dn_left;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    logic           ctick, ftick;
    logic [CSW-1:0] csub;
    logic [FSW-1:0] fsub;
    logic           fine_clr;
    logic           fine_start, late_start;
    logic           coarse_last, fine_last;
    logic [DW-1:0]  lim, elapsed, rem;

    spc_tick_div #(.DIV(COARSE_DIV)) u_coarse_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (meas_i),
        .tick_o  (ctick),
        .phase_o (csub)
    );

    spc_tick_div #(.DIV(FINE_DIV)) u_fine_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (fine_clr),
        .tick_o  (ftick),
        .phase_o (fsub)
    );

    assign fine_clr = meas_i || fine_start || late_start;

    always_comb begin
        lim         = DW'(fine_i) * DW'(FINE_DIV);
        elapsed     = DW'(st_q.fcnt) * DW'(FINE_DIV) + DW'(fsub);
        rem         = (elapsed + DW'(1) >= lim) ? '0 : (lim - elapsed - DW'(1));
        coarse_last = ctick && ({1'b0, st_q.ccnt} + (CRS_W+1)'(1) >= {1'b0, coarse_i});
        fine_last   = ftick && ({1'b0, st_q.fcnt} + (FIN_W+1)'(1) >= {1'b0, fine_i});
    end

    always_comb begin
        st_d       = st_q;
        fine_start = 1'b0;
        late_start = 1'b0;

        if (st_q.dn_left != '0) begin
            st_d.dn_left = st_q.dn_left - DW'(1);
        end

        case (st_q.phase)
            PH_COARSE: begin
                if (ctick) begin
                    st_d.ccnt = st_q.ccnt + CRS_W'(1);
                end
                if (coarse_last) begin
                    st_d.fcnt = '0;
                    if (fine_i != '0) begin
                        st_d.phase = PH_FINE;
                        fine_start = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            PH_FINE: begin
                if (ftick) begin
                    st_d.fcnt = st_q.fcnt + FIN_W'(1);
                end
                if (fine_last || fine_i == '0) begin
                    st_d.fcnt  = '0;
                    st_d.phase = (fine_i != '0) ? PH_LATE : PH_IDLE;
                    late_start = 1'b1;
                end
            end
            PH_LATE: begin
                if (ftick) begin
                    st_d.fcnt = st_q.fcnt + FIN_W'(1);
                end
                if (fine_last || fine_i == '0) begin
                    st_d.fcnt  = '0;
                    st_d.phase = PH_IDLE;
                end
            end
            default: ;
        endcase

        if (meas_i) begin
            if (st_q.phase == PH_COARSE) begin
                st_d.dn_left = lim;
            end else if (st_q.phase == PH_FINE) begin
                st_d.dn_left = rem;
            end
            st_d.ccnt = '0;
            st_d.fcnt = '0;
            if (coarse_i != '0) begin
                st_d.phase = PH_COARSE;
            end else if (fine_i != '0) begin
                st_d.phase = PH_FINE;
            end else begin
                st_d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{phase: PH_IDLE, ccnt: '0, fcnt: '0, dn_left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign late_o  = (st_q.phase == PH_LATE);
    assign early_o = (st_q.dn_left != '0);

    assert_dn_after_edge_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(early_o) |-> $past(meas_i));

    assert_up_ends_on_edge_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (late_o && meas_i) |=> !late_o);

    assert_fine_only_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (meas_i && coarse_i == '0 && fine_i != '0) |=> st_q.phase == PH_FINE);

    assert_coarse_tick_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        csub <= CSW'(COARSE_DIV - 1));

endmodule

// File: rtl/speed_period_cmp.sv
module speed_period_cmp #(
    parameter int unsigned COARSE_DIV = 320,
    parameter int unsigned FINE_DIV   = 20,
    parameter int unsigned CRS_W      = 6,
    parameter int unsigned FIN_W      = 5
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             fb_i,
    input  logic [CRS_W-1:0] coarse_i,
    input  logic [FIN_W-1:0] fine_i,
    input  logic [1:0]       ps_sel_i,
    input  logic             force_up_i,
    input  logic             force_dn_i,
    output logic             up_o,
    output logic             dn_o
);

    logic meas;
    logic late, early;

    spc_prescale u_prescale (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .fb_i   (fb_i),
        .sel_i  (ps_sel_i),
        .meas_o (meas)
    );

    spc_ref_cmp #(
        .COARSE_DIV (COARSE_DIV),
        .FINE_DIV   (FINE_DIV),
        .CRS_W      (CRS_W),
        .FIN_W      (FIN_W)
    ) u_ref_cmp (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .meas_i   (meas),
        .coarse_i (coarse_i),
        .fine_i   (fine_i),
        .late_o   (late),
        .early_o  (early)
    );

    assign up_o = force_up_i || (!force_dn_i && late && !early);
    assign dn_o = !force_up_i && (force_dn_i || early);

    assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(up_o && dn_o));

    assert_force_src_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        force_up_i |-> (up_o && !dn_o));

    assert_force_snk_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (force_dn_i && !force_up_i) |-> (dn_o && !up_o));

endmodule

// File: tb/speed_period_cmp_tb_top.sv
`timescale 1ns/1ps
module speed_period_cmp_tb_top;

    localparam int CT = 320;
    localparam int FT = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fb = 1'b0;
    logic [5:0] coarse = '0;
    logic [4:0] fine = '0;
    logic [1:0] ps_sel = '0;
    logic       f_up = 1'b0;
    logic       f_dn = 1'b0;
    logic       up, dn;

    always #2 clk = ~clk;

    speed_period_cmp dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .fb_i       (fb),
        .coarse_i   (coarse),
        .fine_i     (fine),
        .ps_sel_i   (ps_sel),
        .force_up_i (f_up),
        .force_dn_i (f_dn),
        .up_o       (up),
        .dn_o       (dn)
    );

    typedef struct {
        bit    is_up;
        int    w;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    mon_en = 0;
    int    upw = 0;
    int    dnw = 0;
    bit    done = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_done(bit is_up, int w);
        item_t it;
        if (exp_q.size() == 0) begin
            chk(0, is_up ? "R4 unexpected UP" : "R3 unexpected DOWN", w, 0);
        end else begin
            it = exp_q.pop_front();
            chk(it.is_up == is_up, {it.tag, " pulse kind(1=UP)"}, int'(is_up), int'(it.is_up));
            chk(it.w == w, {it.tag, is_up ? " R4 UP width" : " R3 DOWN width"}, w, it.w);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_en) begin
            if (up && dn) chk(0, "R9 both high", 1, 0);
            if (up) upw++;
            else if (upw > 0) begin pulse_done(1, upw); upw = 0; end
            if (dn) dnw++;
            else if (dnw > 0) begin pulse_done(0, dnw); dnw = 0; end
        end
    end

    task automatic push(bit is_up, int w, string tag);
        item_t it;
        it.is_up = is_up; it.w = w; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic expect_gap(int d, int t, int wl, string tag);
        if (d < t && wl > 0) push(0, (t - d < wl) ? t - d : wl, tag);
        if (d > t && wl > 0) push(1, (d - t < wl) ? d - t : wl, tag);
    endtask

    task automatic raw_edge(int d);
        fb = 1'b1;
        @(negedge clk);
        fb = 1'b0;
        repeat (d - 1) @(negedge clk);
    endtask

    task automatic do_reset(int c, int f, int sel);
        mon_en = 0;
        rst = 1'b1;
        fb = 1'b0;
        coarse = 6'(c);
        fine = 5'(f);
        ps_sel = 2'(sel);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        upw = 0; dnw = 0;
        exp_q.delete();
        mon_en = 1;
    endtask

    task automatic run_seq(int c, int f, int sel, int gaps[], string tag);
        int t = c * CT + f * FT;
        int wl = f * FT;
        do_reset(c, f, sel);
        foreach (gaps[i]) begin
            expect_gap(gaps[i], t, wl, tag);
            raw_edge(gaps[i]);
        end
        if (wl > 0) push(1, wl, {tag, " R5 tail"});
        raw_edge(t + wl + 40);
        chk(exp_q.size() == 0, {tag, " pending pulses"}, exp_q.size(), 0);
    endtask

    task automatic run_ps(int c, int f, int sel, int n, int s, int nmeas, string tag);
        int t = c * CT + f * FT;
        int wl = f * FT;
        int total = n * (nmeas + 1);
        do_reset(c, f, sel);
        for (int k = 1; k <= total; k++) begin
            if (k % n == 0) begin
                if (k < total) expect_gap(n * s, t, wl, tag);
                else if (wl > 0) push(1, wl, {tag, " R5 tail"});
            end
            raw_edge(s);
        end
        repeat (t + wl + 40) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " pending pulses"}, exp_q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        // R1: outputs low in reset and after release
        @(negedge clk);
        chk(!up && !dn, "R1 outputs during reset", int'({up, dn}), 0);
        do_reset(2, 5, 0);
        repeat (5) @(negedge clk);
        chk(!up && !dn, "R1 outputs after reset", int'({up, dn}), 0);

        // R2 R3 R4 R5: T=740, limit 100
        run_seq(2, 5, 0, '{740, 700, 600, 650, 760, 900, 739, 741}, "R2");
        // R10 with select code 3 (treated as /1): T=80, limit 80
        run_seq(0, 4, 3, '{80, 50, 100, 200}, "R10");
        // R6: fine limit zero, no pulses at all
        run_seq(1, 0, 0, '{200, 400}, "R6");

        // R7: prescaler /4 and /6, T=360 limit 40
        run_ps(1, 2, 1, 4, 100, 2, "R7 div4 late");
        run_ps(1, 2, 2, 6, 60, 2, "R7 div6 exact");
        run_ps(1, 2, 1, 4, 85, 2, "R7 div4 early");

        // R8: forced outputs
        do_reset(1, 2, 0);
        mon_en = 0;
        f_up = 1'b1; #1;
        chk(up && !dn, "R8 force source", int'({up, dn}), 2);
        f_dn = 1'b1; #1;
        chk(up && !dn, "R8 both forces, source wins", int'({up, dn}), 2);
        f_up = 1'b0; #1;
        chk(!up && dn, "R8 force sink", int'({up, dn}), 1);
        f_dn = 1'b0; #1;
        chk(!up && !dn, "R8 forces released", int'({up, dn}), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule